// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block performs the configuration step of a scalable vector engine. A one-cycle configure strobe carries a requested element count, an element-width code, a register-grouping code and two policy bits. From these and the fixed vector register length (parameter `VLEN`), the block works out the largest element count one register group can hold. It grants the smaller of that count and the request, and registers the granted length together with the accepted configuration. All scaling is done with shifts on log2 codes, so no divider is needed.

The block also answers a combinational memory-access query against the stored configuration. A load or store may name its own element width. The block returns the resulting effective grouping, flags an effective grouping outside the supported range, and flags a destination register number that is not a legal group base for that grouping. There are 32 architectural vector registers.

Top module: `vcfg_unit`

## Requirements
- R1: After reset the granted length, width code, grouping code and both policy bits read 0 and the illegal flag reads 1.
- R2: The width code maps 0,1,2,3 to 8,16,32,64-bit elements; codes 4 to 7 are unsupported. The grouping field is a 3-bit two's-complement log2: 0,1,2,3 give 1,2,4,8; 7,6,5 give 1/2,1/4,1/8; 4 is unsupported.
- R3: For a legal request the maximum count is VLEN*grouping/width, and the granted length equals min(request, maximum). It appears on the clock edge that samples the strobe.
- R4: An unsupported width code, an unsupported grouping code, or an element width larger than VLEN*grouping sets the illegal flag, forces the granted length to 0 and clears the stored width, grouping and policy bits.
- R5: Without a strobe, every stored output keeps its value whatever the other configure inputs do.
- R6: For a legal request the tail and mask policy bits are stored and exported unchanged.
- R7: The effective grouping for an access width code equals (access width / stored width) * stored grouping. It is reported as a log2 code in the grouping encoding of R2.
- R8: The access-illegal flag is raised when the stored configuration is illegal or the effective grouping lies outside 1/8 to 8. The effective-grouping output then reads 0.
- R9: When the access is legal and the effective grouping G exceeds 1, a register number that is not a multiple of G raises the misalignment flag. With G of 1 or less no misalignment is flagged.
- R10: The `VLEN` parameter accepts powers of two of 128 and above. A 256-bit instance grants twice the count of a 128-bit one for the same legal configuration, unless the request limits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configure strobe |
| cfg_avl | input | AVL_W | Requested element count |
| cfg_sew | input | 3 | Element-width code |
| cfg_lmul | input | 3 | Grouping code (signed log2) |
| cfg_ta | input | 1 | Tail policy bit |
| cfg_ma | input | 1 | Mask policy bit |
| vl | output | log2(VLEN)+1 | Granted element count |
| cur_sew | output | 2 | Stored width code |
| cur_lmul | output | 3 | Stored grouping code |
| cur_ta | output | 1 | Stored tail policy bit |
| cur_ma | output | 1 | Stored mask policy bit |
| cur_ill | output | 1 | Stored configuration illegal |
| mem_eew | input | 2 | Access element-width code |
| mem_vreg | input | 5 | Access register number |
| mem_emul | output | 3 | Effective grouping code |
| mem_illegal | output | 1 | Access illegal |
| mem_misaligned | output | 1 | Register number not a group base |

## Verification
The bench aims at the edges of the grant: a zero request, a request exactly at the maximum and one above it. A wrong comparison there would grant one element too many or too few. It drives the smallest fractional groupings against wide elements, where a design with a wrong shift sign would grant a count instead of flagging illegal. It also drives access widths that push the effective grouping just past 1/8 or 8, where a design would return a wrapped code. Register numbers one off a group base are checked, which catches a design that tests the wrong low bits. Two instances of different `VLEN` run the same random mix, so a design that hard-codes the register length fails on one of them.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    localparam logic [2:0] LMUL_RSVD = 3'b100;

    typedef struct packed {
        logic [1:0] sew;
        logic [2:0] lmul;
        logic       ta;
        logic       ma;
        logic       vill;
    } cfg_fields_t;

    localparam cfg_fields_t CFG_RESET = '{sew: 2'd0, lmul: 3'd0, ta: 1'b0, ma: 1'b0, vill: 1'b1};

endpackage

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax #(
    parameter int LOG_VLEN = 7,
    parameter int VL_W     = LOG_VLEN + 1
) (
    input  logic [2:0]      sew,
    input  logic [2:0]      lmul,
    output logic            legal,
    output logic [VL_W-1:0] vlmax
);
    import vcfg_pkg::*;

    logic signed [7:0] lmul_s;
    logic signed [7:0] sew_s;
    logic signed [7:0] lg;

    // log2(VLMAX) = log2(VLEN) + lmul - (3 + sew)
    always_comb begin
        lmul_s = {{5{lmul[2]}}, lmul};
        sew_s  = {6'b0, sew[1:0]};
        lg     = 8'(LOG_VLEN - 3) + lmul_s - sew_s;
        legal  = !sew[2] && (lmul != LMUL_RSVD) && (lg >= 8'sd0);
        vlmax  = legal ? (VL_W'(1) << lg[4:0]) : '0;
    end

endmodule

// File: rtl/vcfg_emul.sv
module vcfg_emul (
    input  logic [1:0] sew,
    input  logic [2:0] lmul,
    input  logic       vill,
    input  logic [1:0] eew,
    input  logic [4:0] vreg,
    output logic [2:0] emul,
    output logic       illegal,
    output logic       misaligned
);
    logic signed [4:0] e;
    logic [2:0]        mask;

    always_comb begin
        e       = $signed({3'b0, eew}) - $signed({3'b0, sew}) + $signed({{2{lmul[2]}}, lmul});
        illegal = vill || (e < -5'sd3) || (e > 5'sd3);
        emul    = illegal ? 3'd0 : e[2:0];
    end

    // bit i of the register number must be clear when the group spans more than 2^i registers
    for (genvar i = 0; i < 3; i++) begin : g_align
        assign mask[i] = !illegal && (e > $signed(5'(i)));
    end

    assign misaligned = |(vreg[2:0] & mask);

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
    parameter int VLEN  = 128,
    parameter int AVL_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_valid,
    input  logic [AVL_W-1:0]       cfg_avl,
    input  logic [2:0]             cfg_sew,
    input  logic [2:0]             cfg_lmul,
    input  logic                   cfg_ta,
    input  logic                   cfg_ma,
    output logic [$clog2(VLEN):0]  vl,
    output logic [1:0]             cur_sew,
    output logic [2:0]             cur_lmul,
    output logic                   cur_ta,
    output logic                   cur_ma,
    output logic                   cur_ill,
    input  logic [1:0]             mem_eew,
    input  logic [4:0]             mem_vreg,
    output logic [2:0]             mem_emul,
    output logic                   mem_illegal,
    output logic                   mem_misaligned
);
    import vcfg_pkg::*;

    localparam int LOG_VLEN = $clog2(VLEN);
    localparam int VL_W     = LOG_VLEN + 1;

    typedef struct packed {
        logic [VL_W-1:0] vl;
        cfg_fields_t     f;
    } state_t;

    state_t          st_d, st_q;
    logic            cfg_legal;
    logic [VL_W-1:0] vlmax;

    vcfg_vlmax #(.LOG_VLEN(LOG_VLEN), .VL_W(VL_W)) u_vlmax (
        .sew   (cfg_sew),
        .lmul  (cfg_lmul),
        .legal (cfg_legal),
        .vlmax (vlmax)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_valid) begin
            if (cfg_legal) begin
                st_d.vl     = (cfg_avl >= AVL_W'(vlmax)) ? vlmax : cfg_avl[VL_W-1:0];
                st_d.f.sew  = cfg_sew[1:0];
                st_d.f.lmul = cfg_lmul;
                st_d.f.ta   = cfg_ta;
                st_d.f.ma   = cfg_ma;
                st_d.f.vill = 1'b0;
            end else begin
                st_d.vl = '0;
                st_d.f  = CFG_RESET;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vl <= '0;
            st_q.f  <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign vl       = st_q.vl;
    assign cur_sew  = st_q.f.sew;
    assign cur_lmul = st_q.f.lmul;
    assign cur_ta   = st_q.f.ta;
    assign cur_ma   = st_q.f.ma;
    assign cur_ill  = st_q.f.vill;

    vcfg_emul u_emul (
        .sew        (st_q.f.sew),
        .lmul       (st_q.f.lmul),
        .vill       (st_q.f.vill),
        .eew        (mem_eew),
        .vreg       (mem_vreg),
        .emul       (mem_emul),
        .illegal    (mem_illegal),
        .misaligned (mem_misaligned)
    );

    p_vl_le_avl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> (AVL_W'(st_q.vl) <= $past(cfg_avl)));

    p_vl_le_vlmax_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_legal) |=> (st_q.vl <= $past(vlmax)));

    p_ill_zero_vl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.f.vill |-> (st_q.vl == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> $stable(st_q));

    p_ill_cfg_blocks_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.f.vill |-> mem_illegal);

    p_misalign_needs_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_misaligned |-> !mem_illegal);

endmodule

// File: tb/vcfg_unit_tb.sv
`timescale 1ns/1ps
module vcfg_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [31:0] cfg_avl = '0;
    logic [2:0]  cfg_sew = '0;
    logic [2:0]  cfg_lmul = '0;
    logic        cfg_ta = 1'b0;
    logic        cfg_ma = 1'b0;
    logic [1:0]  mem_eew = '0;
    logic [4:0]  mem_vreg = '0;

    logic [7:0]  vl_a;
    logic [8:0]  vl_b;
    logic [1:0]  sew_a, sew_b;
    logic [2:0]  lmul_a, lmul_b, emul_a, emul_b;
    logic        ta_a, ta_b, ma_a, ma_b, ill_a, ill_b;
    logic        mill_a, mill_b, mis_a, mis_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // expected stored state per instance (index 0: VLEN 128, 1: VLEN 256)
    longint   e_vl[2];
    bit [1:0] e_sew[2];
    bit [2:0] e_lmul[2];
    bit       e_ta[2], e_ma[2], e_ill[2];

    always #2.5 clk = ~clk;

    vcfg_unit #(.VLEN(128), .AVL_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_avl(cfg_avl),
        .cfg_sew(cfg_sew), .cfg_lmul(cfg_lmul), .cfg_ta(cfg_ta), .cfg_ma(cfg_ma),
        .vl(vl_a), .cur_sew(sew_a), .cur_lmul(lmul_a), .cur_ta(ta_a), .cur_ma(ma_a),
        .cur_ill(ill_a), .mem_eew(mem_eew), .mem_vreg(mem_vreg), .mem_emul(emul_a),
        .mem_illegal(mill_a), .mem_misaligned(mis_a)
    );

    vcfg_unit #(.VLEN(256), .AVL_W(32)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_avl(cfg_avl),
        .cfg_sew(cfg_sew), .cfg_lmul(cfg_lmul), .cfg_ta(cfg_ta), .cfg_ma(cfg_ma),
        .vl(vl_b), .cur_sew(sew_b), .cur_lmul(lmul_b), .cur_ta(ta_b), .cur_ma(ma_b),
        .cur_ill(ill_b), .mem_eew(mem_eew), .mem_vreg(mem_vreg), .mem_emul(emul_b),
        .mem_illegal(mill_b), .mem_misaligned(mis_b)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void ratio(input bit [2:0] lmul, output longint num, output longint den);
        if (lmul < 3'd4) begin num = 1 << lmul; den = 1; end
        else begin num = 1; den = 1 << (8 - lmul); end
    endfunction

    // R2/R3/R4 model: plain integer arithmetic on bit counts
    function automatic void model_cfg(input int idx, input longint avl, input bit [2:0] sew,
                                      input bit [2:0] lmul, input bit ta, input bit ma);
        longint vlen, sb, num, den, vmax;
        bit legal;
        vlen = 128 << idx;
        sb   = 8 << sew[1:0];
        ratio(lmul, num, den);
        legal = (sew < 3'd4) && (lmul != 3'd4) && (sb * den <= vlen * num);
        if (legal) begin
            vmax = (vlen * num) / (den * sb);
            e_vl[idx]   = (avl < vmax) ? avl : vmax;
            e_sew[idx]  = sew[1:0];
            e_lmul[idx] = lmul;
            e_ta[idx]   = ta;
            e_ma[idx]   = ma;
            e_ill[idx]  = 0;
        end else begin
            e_vl[idx] = 0; e_sew[idx] = 0; e_lmul[idx] = 0;
            e_ta[idx] = 0; e_ma[idx] = 0; e_ill[idx] = 1;
        end
    endfunction

    task automatic check_state(input string req);
        chk(req, "vl128",   vl_a,   e_vl[0]);
        chk(req, "sew128",  sew_a,  e_sew[0]);
        chk(req, "lmul128", lmul_a, e_lmul[0]);
        chk(req, "ta128",   ta_a,   e_ta[0]);
        chk(req, "ma128",   ma_a,   e_ma[0]);
        chk(req, "ill128",  ill_a,  e_ill[0]);
        chk(req, "vl256",   vl_b,   e_vl[1]);
        chk(req, "sew256",  sew_b,  e_sew[1]);
        chk(req, "lmul256", lmul_b, e_lmul[1]);
        chk(req, "ill256",  ill_b,  e_ill[1]);
    endtask

    // R7/R8/R9 model for one instance
    task automatic check_mem(input int idx, input string req, input bit [1:0] eew, input bit [4:0] vreg);
        longint num, den, ne, de, g;
        bit ill, mis;
        bit [2:0] code;
        ratio(e_lmul[idx], num, den);
        ne = (8 << eew) * num;
        de = (8 << e_sew[idx]) * den;
        ill = e_ill[idx] || (ne * 8 < de) || (ne > de * 8);
        code = 0; mis = 0;
        if (!ill) begin
            if (ne >= de) code = 3'($clog2(ne / de));
            else code = 3'(-$clog2(de / ne));
            if (ne > de) begin g = ne / de; mis = (vreg % g) != 0; end
        end
        if (idx == 0) begin
            chk(req, "emul128", emul_a, code);
            chk(req, "memill128", mill_a, ill);
            chk(req, "mis128", mis_a, mis);
        end else begin
            chk(req, "emul256", emul_b, code);
            chk(req, "memill256", mill_b, ill);
            chk(req, "mis256", mis_b, mis);
        end
    endtask

    task automatic do_cfg(input string req, input longint avl, input bit [2:0] sew,
                          input bit [2:0] lmul, input bit ta, input bit ma);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_avl = 32'(avl); cfg_sew = sew; cfg_lmul = lmul;
        cfg_ta = ta; cfg_ma = ma;
        model_cfg(0, avl, sew, lmul, ta, ma);
        model_cfg(1, avl, sew, lmul, ta, ma);
        @(negedge clk);
        cfg_valid = 1'b0;
        #1 check_state(req);
    endtask

    task automatic do_mem(input string req, input bit [1:0] eew, input bit [4:0] vreg);
        mem_eew = eew; mem_vreg = vreg;
        #1;
        check_mem(0, req, eew, vreg);
        check_mem(1, req, eew, vreg);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < 2; i++) model_cfg(i, 0, 3'd4, 3'd0, 0, 0);
        repeat (3) @(negedge clk);
        #1 check_state("R1");
        rst_n = 1'b1;

        // R3 boundaries: e8 m1 at VLEN 128 gives 16, at 256 gives 32
        do_cfg("R3", 0, 3'd0, 3'd0, 0, 0);
        do_cfg("R3", 16, 3'd0, 3'd0, 0, 0);
        do_cfg("R3", 17, 3'd0, 3'd0, 0, 0);
        do_cfg("R10", 1000, 3'd0, 3'd3, 1, 0);
        do_cfg("R2", 1000, 3'd1, 3'd5, 0, 1);   // e16 mf8: 1 element at 128
        // R4 illegal cases
        do_cfg("R4", 50, 3'd3, 3'd5, 1, 1);     // e64 mf8
        do_cfg("R4", 50, 3'd4, 3'd0, 1, 1);     // bad width code
        do_cfg("R4", 50, 3'd0, 3'd4, 1, 1);     // reserved grouping
        do_mem("R8", 2'd0, 5'd0);
        // R6 policy bits
        do_cfg("R6", 7, 3'd2, 3'd1, 1, 0);
        do_cfg("R6", 7, 3'd2, 3'd7, 0, 1);
        // R5 hold
        @(negedge clk);
        cfg_avl = 32'd3; cfg_sew = 3'd6; cfg_lmul = 3'd4; cfg_ta = 1; cfg_ma = 0;
        repeat (2) @(negedge clk);
        #1 check_state("R5");
        // R7/R8/R9 directed: e8 m8
        do_cfg("R7", 500, 3'd0, 3'd3, 0, 0);
        do_mem("R8", 2'd3, 5'd0);               // EMUL 64
        do_mem("R7", 2'd0, 5'd8);
        do_mem("R9", 2'd0, 5'd9);
        do_mem("R9", 2'd0, 5'd12);
        do_cfg("R9", 500, 3'd1, 3'd2, 0, 0);    // e16 m4
        do_mem("R9", 2'd2, 5'd8);               // EMUL 8
        do_mem("R9", 2'd0, 5'd2);               // EMUL 2
        do_mem("R9", 2'd0, 5'd3);
        do_cfg("R8", 500, 3'd3, 3'd6, 0, 0);    // e64 mf4 at 256 only
        do_mem("R8", 2'd0, 5'd1);               // EMUL 1/32 or illegal cfg

        // random mix
        for (int k = 0; k < 400; k++) begin
            longint avl;
            avl = ($urandom % 4 == 0) ? longint'($urandom) : longint'($urandom % 300);
            do_cfg("R3", avl, 3'($urandom % 5 == 0 ? $urandom : $urandom % 4),
                   3'($urandom), 1'($urandom), 1'($urandom));
            for (int m = 0; m < 2; m++) do_mem("R7", 2'($urandom), 5'($urandom));
        end

        finish_run();
    end

endmodule